// File: doc/BRIEF.md
# Root Port Link Bring-Up Sequencer

This block walks a PCI Express root port from reset to an established link without processor help. A start pulse launches a fixed sequence. The sequence can first pulse a reset to the add-in card. It then keeps link training stopped while it programs the controller as a root complex and sets the target link generation. After that it lets training run and waits, with a timeout, until both the data-link layer and the PHY report link up. The training state machine and the PHY sit outside this block. The block reaches them only through a simple register write port and a few status inputs.

Once the link is up, the sequencer waits a short settling interval so that speed negotiation can finish. It then reports success together with the negotiated speed and lane width. If the link never comes up, it reports failure. One parameter, the clock cycles per microsecond, scales every interval. The done and result outputs hold their values until the next start, so a boot controller can launch the sequence and poll it.

Top module: `link_bringup_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, busy, done, link_ok, card_rst and wr_en are 0, and link_speed and link_width are 0.
- R2: If card_rst_en is 1 at start, card_rst is high for CARD_RST_US microseconds (within three cycles). It then stays low for CARD_REL_US microseconds (within four cycles) before the first register write. If card_rst_en is 0, card_rst never rises.
- R3: If the link is not up when configuration begins, the first write goes to the control word at address 0x040. It carries the current device type in bits 7:4 and bit 2 (training enable) cleared. If the link is already up, this write is left out.
- R4: The next write goes to address 0x040, with bits 7:4 set to 4 (root complex; 0 means endpoint and 1 means legacy endpoint) and bit 2 keeping its last written value.
- R5: Two writes follow: first to address 0x044, then to address 0x048. Each carries the generation captured at start (1, 2 or 3) in bits 3:0, with every other bit 0.
- R6: If the link is still not up after configuration, a last write to address 0x040 sets bits 7:4 to 4 and bit 2 to 1. If the link is up, this write is left out.
- R7: The link counts as up only when sts_dl_up and sts_phy_up are both 1 at the same time. Either one alone leads to the timeout outcome.
- R8: If the link is not up within LINK_TO_US microseconds of the training-enable write, done rises and link_ok stays 0, within four cycles of that limit. link_speed and link_width are then 0.
- R9: After link-up the block waits SETTLE_US microseconds (within five cycles) and then raises done and link_ok. link_speed carries lnk_stat bits 19:16 and link_width carries bits 23:20.
- R10: A start while idle clears done and link_ok on the next cycle. Without a start, done, link_ok and the reported fields hold their values.
- R11: A start received while busy is ignored: the sequence, its writes and its timing carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that launches the sequence when idle |
| card_rst_en | input | 1 | Pulse the add-in card reset before configuring |
| req_gen | input | 4 | Requested link generation, captured at start |
| sts_dl_up | input | 1 | Data-link layer up status |
| sts_phy_up | input | 1 | PHY link up status |
| lnk_stat | input | 8 (bits 23:16) | Link status: 19:16 negotiated speed, 23:20 negotiated width |
| card_rst | output | 1 | Add-in card reset, active high |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until next start |
| link_ok | output | 1 | Link established, valid with done |
| link_speed | output | 4 | Negotiated speed at success, else 0 |
| link_width | output | 4 | Negotiated width at success, else 0 |

## Verification
The assertions assume that the status inputs are synchronous to clk and that req_gen is a legal generation at the cycle of start. They also assume that the controller answers only through its status lines. Nothing reads back the written registers. The stimulus changes status and start only on falling edges. It raises link-up bits only after the training-enable write has been seen, or holds them up from before start to model a link that is already trained. It pulses start for exactly one cycle, and it also pulses start mid-sequence to probe the rule that a start while busy is ignored.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  localparam int REG_W = 32;

  // control word field positions decoded by the controller
  localparam int TRAIN_BIT = 2;
  localparam int DEV_LSB   = 4;

  localparam logic [3:0] DEV_ENDPOINT = 4'd0;
  localparam logic [3:0] DEV_LEGACY   = 4'd1;
  localparam logic [3:0] DEV_ROOT     = 4'd4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_HI,
    S_RST_LO,
    S_CFG_STOP,
    S_CFG_TYPE,
    S_CFG_SPDC,
    S_CFG_SPDP,
    S_CFG_RUN,
    S_WAIT_UP,
    S_SETTLE
  } seq_st_e;

  function automatic logic [REG_W-1:0] ctrl_word(input logic [3:0] dev,
                                                 input logic train);
    logic [REG_W-1:0] w;
    w = '0;
    w[DEV_LSB +: 4] = dev;
    w[TRAIN_BIT]    = train;
    return w;
  endfunction

endpackage

// File: rtl/lbs_rst_sync.sv
module lbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lbs_us_timer.sv
module lbs_us_timer #(
  parameter int CYC_PER_US = 200,
  parameter int CNT_W      = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_us,
  output logic             expired
);

  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (load) begin
      pre_d = '0;
      cnt_d = load_us;
    end else if (cnt_q != '0) begin
      if (pre_q == PRE_MAX) begin
        pre_d = '0;
        cnt_d = cnt_q - 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R8: remaining time drops by at most one microsecond per cycle
  p_tick_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1));

  // R9: an expired timer stays expired until reloaded
  p_expired_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);

endmodule

// File: rtl/lbs_link_mon.sv
module lbs_link_mon (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sts_dl_up,
  input  logic        sts_phy_up,
  input  logic [23:16] lnk_stat,
  output logic        link_up,
  output logic [3:0]  cur_speed,
  output logic [3:0]  cur_width
);

  logic       up_q;
  logic [3:0] spd_q, wid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      spd_q <= '0;
      wid_q <= '0;
    end else begin
      up_q  <= sts_dl_up & sts_phy_up;
      spd_q <= lnk_stat[19:16];
      wid_q <= lnk_stat[23:20];
    end
  end

  assign link_up   = up_q;
  assign cur_speed = spd_q;
  assign cur_width = wid_q;

endmodule

// File: rtl/lbs_wr_port.sv
module lbs_wr_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      en_q <= req;
      if (req) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  assign wr_en   = en_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R3: a strobe appears only one cycle after a sequencer request
  p_strobe_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(req));

  // R5: address and data hold between strobes
  p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req) |-> ($stable(wr_addr) && $stable(wr_data)));

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int CYC_PER_US  = 200,
  parameter int CARD_RST_US = 200000,
  parameter int CARD_REL_US = 200000,
  parameter int LINK_TO_US  = 100000,
  parameter int SETTLE_US   = 100,
  parameter int ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] ADDR_GCTRL   = 12'h040,
  parameter logic [ADDR_W-1:0] ADDR_SPD_CTL = 12'h044,
  parameter logic [ADDR_W-1:0] ADDR_SPD_CAP = 12'h048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              card_rst_en,
  input  logic [3:0]        req_gen,
  input  logic              sts_dl_up,
  input  logic              sts_phy_up,
  input  logic [23:16]      lnk_stat,
  output logic              card_rst,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              link_ok,
  output logic [3:0]        link_speed,
  output logic [3:0]        link_width
);

  localparam int MAX_A  = (CARD_RST_US > CARD_REL_US) ? CARD_RST_US : CARD_REL_US;
  localparam int MAX_B  = (LINK_TO_US > SETTLE_US) ? LINK_TO_US : SETTLE_US;
  localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_US + 1);

  localparam logic [CNT_W-1:0] T_RST    = CNT_W'(CARD_RST_US);
  localparam logic [CNT_W-1:0] T_REL    = CNT_W'(CARD_REL_US);
  localparam logic [CNT_W-1:0] T_LINK   = CNT_W'(LINK_TO_US);
  localparam logic [CNT_W-1:0] T_SETTLE = CNT_W'(SETTLE_US);

  logic rst_sync_n;

  lbs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // state and captured settings
  seq_st_e    st_q, st_d;
  logic [3:0] gen_q;
  logic [3:0] dev_q;
  logic       train_q;
  logic       done_q, ok_q;
  logic [3:0] spd_q, wid_q;

  // sequencer requests
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              wr_req;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [REG_W-1:0]  wr_data_d;
  logic              fin;
  logic              fin_ok;
  logic              launch;

  logic       link_up;
  logic [3:0] cur_speed, cur_width;

  lbs_us_timer #(.CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (tmr_load),
    .load_us (tmr_val),
    .expired (tmr_exp)
  );

  lbs_link_mon u_mon (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sts_dl_up  (sts_dl_up),
    .sts_phy_up (sts_phy_up),
    .lnk_stat   (lnk_stat),
    .link_up    (link_up),
    .cur_speed  (cur_speed),
    .cur_width  (cur_width)
  );

  lbs_wr_port #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (wr_req),
    .req_addr (wr_addr_d),
    .req_data (wr_data_d),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    wr_req    = 1'b0;
    wr_addr_d = '0;
    wr_data_d = '0;
    fin       = 1'b0;
    fin_ok    = 1'b0;
    launch    = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          launch = 1'b1;
          if (card_rst_en) begin
            st_d     = S_RST_HI;
            tmr_load = 1'b1;
            tmr_val  = T_RST;
          end else begin
            st_d = S_CFG_STOP;
          end
        end
      end
      S_RST_HI: begin
        if (tmr_exp) begin
          st_d     = S_RST_LO;
          tmr_load = 1'b1;
          tmr_val  = T_REL;
        end
      end
      S_RST_LO: begin
        if (tmr_exp) st_d = S_CFG_STOP;
      end
      S_CFG_STOP: begin
        if (!link_up) begin
          wr_req    = 1'b1;
          wr_addr_d = ADDR_GCTRL;
          wr_data_d = ctrl_word(dev_q, 1'b0);
        end
        st_d = S_CFG_TYPE;
      end
      S_CFG_TYPE: begin
        wr_req    = 1'b1;
        wr_addr_d = ADDR_GCTRL;
        wr_data_d = ctrl_word(DEV_ROOT, train_q);
        st_d      = S_CFG_SPDC;
      end
      S_CFG_SPDC: begin
        wr_req    = 1'b1;
        wr_addr_d = ADDR_SPD_CTL;
        wr_data_d = {{(REG_W-4){1'b0}}, gen_q};
        st_d      = S_CFG_SPDP;
      end
      S_CFG_SPDP: begin
        wr_req    = 1'b1;
        wr_addr_d = ADDR_SPD_CAP;
        wr_data_d = {{(REG_W-4){1'b0}}, gen_q};
        st_d      = S_CFG_RUN;
      end
      S_CFG_RUN: begin
        if (!link_up) begin
          wr_req    = 1'b1;
          wr_addr_d = ADDR_GCTRL;
          wr_data_d = ctrl_word(DEV_ROOT, 1'b1);
        end
        st_d     = S_WAIT_UP;
        tmr_load = 1'b1;
        tmr_val  = T_LINK;
      end
      S_WAIT_UP: begin
        if (link_up) begin
          st_d     = S_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = T_SETTLE;
        end else if (tmr_exp) begin
          st_d = S_IDLE;
          fin  = 1'b1;
        end
      end
      S_SETTLE: begin
        if (tmr_exp) begin
          st_d   = S_IDLE;
          fin    = 1'b1;
          fin_ok = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= S_IDLE;
      gen_q   <= '0;
      dev_q   <= DEV_ENDPOINT;
      train_q <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      spd_q   <= '0;
      wid_q   <= '0;
    end else begin
      st_q <= st_d;
      if (launch) begin
        gen_q  <= req_gen;
        done_q <= 1'b0;
        ok_q   <= 1'b0;
        spd_q  <= '0;
        wid_q  <= '0;
      end
      if (wr_req && (wr_addr_d == ADDR_GCTRL)) begin
        dev_q   <= wr_data_d[DEV_LSB +: 4];
        train_q <= wr_data_d[TRAIN_BIT];
      end
      if (fin) begin
        done_q <= 1'b1;
        ok_q   <= fin_ok;
        spd_q  <= fin_ok ? cur_speed : 4'd0;
        wid_q  <= fin_ok ? cur_width : 4'd0;
      end
    end
  end

  assign card_rst   = (st_q == S_RST_HI);
  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign link_ok    = ok_q;
  assign link_speed = spd_q;
  assign link_width = wid_q;

  // R10: a start while idle clears the previous result at once
  p_launch_clears_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && start) |=> (busy && !done && !link_ok));

  // R10: results hold without a start
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !start) |=> (done && $stable(link_ok) && $stable(link_speed) && $stable(link_width)));

  // R9: success is reported only together with done
  p_ok_with_done_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_ok |-> done);

  // R8: a failed bring-up reports zero speed and width
  p_fail_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !link_ok) |-> (link_speed == 4'd0 && link_width == 4'd0));

  // R2: no register traffic while the card is held in reset
  p_rst_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    card_rst |-> !wr_en);

  // R7: settling starts only from a sampled link-up
  p_settle_needs_up_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_WAIT_UP && !link_up) |=> (st_q != S_SETTLE));

  // R11: a start while busy leaves the captured generation untouched
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start) |=> (gen_q == $past(gen_q)));

  // R6: training is never enabled with a non-root device type
  p_train_type_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == ADDR_GCTRL && wr_data[TRAIN_BIT]) |-> (wr_data[DEV_LSB +: 4] == DEV_ROOT));

endmodule

// File: tb/tb_link_bringup_seq.sv
`timescale 1ns/100ps
module tb_link_bringup_seq;

  localparam int CYC = 4;
  localparam int RST_US = 10;
  localparam int REL_US = 8;
  localparam int TO_US = 25;
  localparam int SET_US = 5;
  localparam logic [11:0] A_CTRL = 12'h040;
  localparam logic [11:0] A_SPDC = 12'h044;
  localparam logic [11:0] A_SPDP = 12'h048;

  // vector: [31] card reset, [27:24] gen, [21:20] link mode
  // (0 none, 1 data-link only, 2 PHY only, 3 both), [19:12] delay after
  // training enable, [7:4] reported speed, [3:0] reported width
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0330A034,
    32'h81300011,
    32'h02100000,
    32'h02200000,
    32'h03000000,
    32'h0235A028
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic card_rst_en = 1'b0;
  logic [3:0] req_gen = 4'd0;
  logic sts_dl_up = 1'b0;
  logic sts_phy_up = 1'b0;
  logic [23:16] lnk_stat = 8'h00;
  logic card_rst, wr_en, busy, done, link_ok;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] link_speed, link_width;

  int nchk = 0;
  int nfail = 0;
  int cycles = 0;
  logic [3:0] exp_dev = 4'd0;
  logic exp_train = 1'b0;

  always #2.5 clk = ~clk;

  link_bringup_seq #(
    .CYC_PER_US(CYC), .CARD_RST_US(RST_US), .CARD_REL_US(REL_US),
    .LINK_TO_US(TO_US), .SETTLE_US(SET_US)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .card_rst_en(card_rst_en),
    .req_gen(req_gen), .sts_dl_up(sts_dl_up), .sts_phy_up(sts_phy_up),
    .lnk_stat(lnk_stat), .card_rst(card_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .link_ok(link_ok), .link_speed(link_speed), .link_width(link_width)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nchk + 1, nfail);
      $finish;
    end
  end

  task automatic run_seq(input bit use_rst, input logic [3:0] gen,
                         input logic [1:0] mode, input int dly,
                         input logic [3:0] spd, input logic [3:0] wid,
                         input bit pre_up, input bit poke);
    logic [11:0] wa [8];
    logic [31:0] wd [8];
    logic [11:0] ea [8];
    logic [31:0] ed [8];
    int wn = 0;
    int en = 0;
    int t = 0;
    int rst_hi = 0;
    int rel_lo = 0;
    int en_t = -1;
    int up_t = -1;
    bit up_set = 1'b0;
    bit ok_exp;
    lnk_stat = {wid, spd};
    sts_dl_up = pre_up;
    sts_phy_up = pre_up;
    @(negedge clk);
    card_rst_en = use_rst;
    req_gen = gen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    req_gen = 4'hF;
    chk(busy && !done && !link_ok, "R10", "start clears result", {busy, done, link_ok}, 3'b100);
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      start = 1'b0;
      if (card_rst) rst_hi++;
      if (rst_hi > 0 && !card_rst && wn == 0) rel_lo++;
      if (wr_en) begin
        if (wn < 8) begin
          wa[wn] = wr_addr;
          wd[wn] = wr_data;
        end
        wn++;
        if (wr_addr == A_CTRL && wr_data[2]) en_t = t;
      end
      if (!pre_up && en_t >= 0 && !up_set && mode != 2'd0 && (t - en_t) >= dly) begin
        up_set = 1'b1;
        sts_dl_up = mode[0];
        sts_phy_up = mode[1];
        if (mode == 2'd3) up_t = t;
      end
      if (poke && en_t >= 0 && t == en_t + 20) begin
        start = 1'b1;
        req_gen = 4'd1;
      end
    end
    // expected write list
    if (!pre_up) begin
      ea[en] = A_CTRL; ed[en] = {24'h0, exp_dev, 4'h0}; en++;
      exp_train = 1'b0;
    end
    ea[en] = A_CTRL; ed[en] = {24'h0, 4'h4, 1'b0, exp_train, 2'b00}; en++;
    exp_dev = 4'h4;
    ea[en] = A_SPDC; ed[en] = {28'h0, gen}; en++;
    ea[en] = A_SPDP; ed[en] = {28'h0, gen}; en++;
    if (!pre_up) begin
      ea[en] = A_CTRL; ed[en] = 32'h44; en++;
      exp_train = 1'b1;
    end
    chk(wn == en, "R3", "write count (R6 R11)", wn, en);
    for (int i = 0; i < en && i < wn; i++) begin
      chk(wa[i] == ea[i], "R4", "write address (R3 R5 R6)", wa[i], ea[i]);
      chk(wd[i] == ed[i], "R5", "write data (R3 R4 R6)", wd[i], ed[i]);
    end
    ok_exp = pre_up || (mode == 2'd3);
    chk(done == 1'b1, "R8", "done raised", done, 1);
    chk(link_ok == ok_exp, "R7", "link_ok outcome", link_ok, ok_exp);
    chk(link_speed == (ok_exp ? spd : 4'd0), "R9", "link_speed", link_speed, ok_exp ? spd : 4'd0);
    chk(link_width == (ok_exp ? wid : 4'd0), "R9", "link_width", link_width, ok_exp ? wid : 4'd0);
    if (use_rst) begin
      chk(rst_hi >= RST_US*CYC - 1 && rst_hi <= RST_US*CYC + 3, "R2", "card reset high cycles", rst_hi, RST_US*CYC);
      chk(rel_lo >= REL_US*CYC && rel_lo <= REL_US*CYC + 4, "R2", "card release cycles", rel_lo, REL_US*CYC);
    end else begin
      chk(rst_hi == 0, "R2", "card reset stays low", rst_hi, 0);
    end
    if (!ok_exp) begin
      chk(en_t >= 0 && (t - en_t) >= TO_US*CYC && (t - en_t) <= TO_US*CYC + 4,
          "R8", "timeout interval (R11)", t - en_t, TO_US*CYC);
    end else if (!pre_up) begin
      chk(up_t >= 0 && (t - up_t) >= SET_US*CYC && (t - up_t) <= SET_US*CYC + 5,
          "R9", "settle interval", t - up_t, SET_US*CYC);
    end
  endtask

  initial begin
    // R1: state in and after reset
    repeat (3) @(negedge clk);
    chk(!busy && !done && !link_ok && !card_rst && !wr_en, "R1", "outputs in reset",
        {busy, done, link_ok, card_rst, wr_en}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!busy && !done && !link_ok, "R1", "status after reset", {busy, done, link_ok}, 0);
    chk(!card_rst && !wr_en, "R1", "card reset and strobe idle", {card_rst, wr_en}, 0);
    chk(link_speed == 0 && link_width == 0, "R1", "fields zero", {link_speed, link_width}, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_seq(VEC[v][31], VEC[v][27:24], VEC[v][21:20], int'(VEC[v][19:12]),
              VEC[v][7:4], VEC[v][3:0], 1'b0, 1'b0);
      sts_dl_up = 1'b0;
      sts_phy_up = 1'b0;
    end

    // R10: result holds with no start
    begin
      bit held = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!(done && link_ok && link_speed == 4'd2 && link_width == 4'd8)) held = 1'b0;
      end
      chk(held, "R10", "result held without start", held, 1);
    end

    // R3 R6: link already up skips stop and enable writes
    run_seq(1'b0, 4'd3, 2'd3, 0, 4'd3, 4'd2, 1'b1, 1'b0);
    sts_dl_up = 1'b0;
    sts_phy_up = 1'b0;

    // R11: start while busy is ignored
    run_seq(1'b0, 4'd2, 2'd0, 0, 4'd1, 4'd1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy && done, "R11", "no relaunch after busy start", {busy, done}, 1);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule